// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This block is a single-channel copy engine that software starts by writing a few registers. Software first loads a source base, a destination base and a transfer count through a 32-bit register port. It then writes the control word with the enable bit set. A second write sets the software-request bit as well, and that write launches the copy. The engine then reads words from memory through a simple request/acknowledge master port and writes them back at the destination. It moves one word per counted transfer, or four words when burst mode is selected.

Each address pointer can step upward or downward, and the source pointer can also be held fixed. Progress is visible in read-only current-pointer and current-count registers. A terminal-count flag reports completion. An error flag reports a refused start or a bus fault. Both flags are sticky and are cleared by writing one to them. An interrupt line combines terminal count with an interrupt-enable bit.

Top module: `mem_copy_dma`

## Requirements
- R1: After reset, all registers read zero, mem_req is low and irq is low.
- R2: Register word indices are 0 control, 1 source base, 2 destination base, 3 count, 4 current source, 5 current destination, 6 current count, and 7 reads zero. Control bit 0 is enable, bits 3:2 mode, bit 4 destination step down, bit 5 source step down, bit 7 source fixed, bit 8 interrupt enable, bit 9 burst, bits 13:12 width, bit 15 demand, bit 16 software request, bit 18 terminal count and bit 20 error. The other bits read zero, and bit 16 always reads zero. Writes to indices 4 to 6 have no effect.
- R3: A copy starts only on a control write that has both bit 0 and bit 16 set while the engine is idle. A write with bit 16 set and bit 0 clear causes no bus activity.
- R4: With burst off, each counted transfer reads one word and then writes it, and mem_req, mem_we, mem_addr and mem_wdata stay stable until mem_ack.
- R5: With burst on (bit 9), each counted transfer reads four consecutive words and then writes those four words in the same order.
- R6: Each beat steps an address by 4. The step is upward when the address's direction bit is 0 and downward when it is 1. Bit 7 holds the source address fixed.
- R7: At start, the current registers are loaded from the base registers. After a full copy, current count is 0 and each current pointer sits one step past its last beat.
- R8: Terminal count (bit 18) sets when the last transfer completes, and writing one to bit 18 clears it. A start with count 0 sets it at once with no bus request.
- R9: A start sets the error bit (bit 20) and makes no bus request in two cases. The first is a width field other than 2'b10. The second is misalignment: with burst on, either base has a nonzero value in bits 3:0; with burst off, either base has a nonzero value in bits 1:0.
- R10: A bus error response (mem_err with mem_ack) sets bit 20, ends the copy without terminal count, and drops mem_req on the next cycle. Writing one to bit 20 clears it.
- R11: Clearing enable during a copy stops the engine once the beat in progress is acknowledged, with no terminal count.
- R12: irq is high exactly when bit 8 and terminal count are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_idx |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted or completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situations to reach from the ports are the ones that need an event in the middle of a copy: an abort or a fault that lands partway through. The bench memory model adds a programmable number of wait cycles before each acknowledge, which stretches each beat so that a control write clearing enable arrives while a beat is pending. The same model can return an error on one chosen address, so a fault lands on the third read of a copy. In each case the scoreboard confirms that only the writes before the stop reached memory, and the current-count register shows where the engine halted.

// File: rtl/mem_copy_dma.sv
module mem_copy_dma #(
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        irq
);
  localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int PAD_W = 32 - CNT_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t st;

  logic en_q, ddir_q, sdir_q, sfix_q, sien_q, bme_q, dm_q, tc_q, err_q;
  logic [1:0] mode_q, tws_q;
  logic [31:0] base_src, base_dst, cur_src, cur_dst;
  logic [CNT_W-1:0] base_cnt, cur_cnt;
  logic [31:0] data_q [BURST_LEN];
  logic [IDX_W-1:0] idx;

  function automatic logic [31:0] step(input logic [31:0] a, input logic down);
    return down ? a - 32'd4 : a + 32'd4;
  endfunction

  logic ctrl_wr, start, en_eff, last_beat, bad_width, misalign;
  assign ctrl_wr   = reg_wr && reg_idx == 3'd0;
  assign start     = ctrl_wr && reg_wdata[0] && reg_wdata[16] && st == S_IDLE;
  assign en_eff    = ctrl_wr ? reg_wdata[0] : en_q;
  assign last_beat = bme_q ? (idx == LAST_IDX) : 1'b1;
  assign bad_width = reg_wdata[13:12] != 2'b10;
  assign misalign  = reg_wdata[9] ? ((|base_src[3:0]) || (|base_dst[3:0]))
                                  : ((|base_src[1:0]) || (|base_dst[1:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {en_q, ddir_q, sdir_q, sfix_q, sien_q, bme_q, dm_q, tc_q, err_q} <= '0;
      mode_q <= '0; tws_q <= '0;
      base_src <= '0; base_dst <= '0; base_cnt <= '0;
      cur_src <= '0; cur_dst <= '0; cur_cnt <= '0;
      idx <= '0;
      for (int i = 0; i < BURST_LEN; i++) data_q[i] <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_idx)
          3'd0: begin
            en_q   <= reg_wdata[0];
            mode_q <= reg_wdata[3:2];
            ddir_q <= reg_wdata[4];
            sdir_q <= reg_wdata[5];
            sfix_q <= reg_wdata[7];
            sien_q <= reg_wdata[8];
            bme_q  <= reg_wdata[9];
            tws_q  <= reg_wdata[13:12];
            dm_q   <= reg_wdata[15];
            if (reg_wdata[18]) tc_q <= 1'b0;
            if (reg_wdata[20]) err_q <= 1'b0;
          end
          3'd1: base_src <= reg_wdata;
          3'd2: base_dst <= reg_wdata;
          3'd3: base_cnt <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (start) begin
        tc_q <= 1'b0;
        err_q <= 1'b0;
        cur_src <= base_src;
        cur_dst <= base_dst;
        cur_cnt <= base_cnt;
        idx <= '0;
        if (bad_width || misalign) err_q <= 1'b1;
        else if (base_cnt == '0) tc_q <= 1'b1;
        else st <= S_RD;
      end
      case (st)
        S_RD: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            data_q[idx] <= mem_rdata;
            if (!sfix_q) cur_src <= step(cur_src, sdir_q);
            if (!en_eff) st <= S_IDLE;
            else if (last_beat) begin
              idx <= '0;
              st <= S_WR;
            end else idx <= idx + 1'b1;
          end
        end
        S_WR: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            cur_dst <= step(cur_dst, ddir_q);
            if (last_beat) begin
              idx <= '0;
              cur_cnt <= cur_cnt - 1'b1;
              if (cur_cnt == CNT_W'(1)) begin
                tc_q <= 1'b1;
                st <= S_IDLE;
              end else if (!en_eff) st <= S_IDLE;
              else st <= S_RD;
            end else begin
              idx <= idx + 1'b1;
              if (!en_eff) st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  logic [31:0] ctrl_word;
  assign ctrl_word = {11'b0, err_q, 1'b0, tc_q, 2'b0, dm_q, 1'b0, tws_q, 2'b0,
                      bme_q, sien_q, sfix_q, 1'b0, sdir_q, ddir_q, mode_q, 1'b0, en_q};

  always_comb begin
    case (reg_idx)
      3'd0: reg_rdata = ctrl_word;
      3'd1: reg_rdata = base_src;
      3'd2: reg_rdata = base_dst;
      3'd3: reg_rdata = {{PAD_W{1'b0}}, base_cnt};
      3'd4: reg_rdata = cur_src;
      3'd5: reg_rdata = cur_dst;
      3'd6: reg_rdata = {{PAD_W{1'b0}}, cur_cnt};
      default: reg_rdata = '0;
    endcase
  end

  assign mem_req   = st != S_IDLE;
  assign mem_we    = st == S_WR;
  assign mem_addr  = (st == S_WR) ? cur_dst : cur_src;
  assign mem_wdata = data_q[idx];
  assign irq       = sien_q && tc_q;

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_tc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> $past(mem_ack && mem_we) || $past(reg_wr));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !mem_req);

  p_fault_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !mem_req && err_q);

  p_req_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> en_q);
endmodule

// File: tb/mem_copy_dma_tb.sv
`timescale 1ns/1ps
module mem_copy_dma_tb;
  localparam logic [31:0] EN = 32'h1, DDIR = 32'h10, SDIR = 32'h20, SFIX = 32'h80,
    SIEN = 32'h100, BME = 32'h200, W32 = 32'h2000, SREQ = 32'h10000,
    TCB = 32'h40000, ERRB = 32'h100000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_idx = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

  mem_copy_dma u_dut (.clk, .rst_n, .reg_wr, .reg_idx, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .mem_err, .irq);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, grants = 0, wait_mode = 0, wcnt = 0;
  bit err_en = 0, done = 0;
  logic [31:0] err_addr = 0;
  logic [31:0] mem [0:1023];
  logic [63:0] exp_q [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0; mem_err = 0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= wait_mode) begin
        mem_ack = 1; grants++;
        if (err_en && mem_addr == err_addr) mem_err = 1;
        else if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          if (exp_q.size() == 0) check(0, "R4 unexpected write", mem_addr, 0);
          else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check({mem_addr, mem_wdata} == e, "R4/R5/R6 write beat", mem_addr ^ mem_wdata, e[63:32] ^ e[31:0]);
          end
        end else mem_rdata = mem[mem_addr[11:2]];
      end else wcnt++;
    end
  end

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk); reg_idx = i; #1 d = reg_rdata;
  endtask

  task automatic push_exp(input logic [31:0] s, input logic [31:0] d, input int cnt,
                          input logic [31:0] ctl, input int limit);
    int nb, n;
    nb = ctl[9] ? 4 : 1; n = 0;
    for (int t = 0; t < cnt; t++)
      for (int b = 0; b < nb; b++) begin
        if (n < limit) exp_q.push_back({d, mem[s[11:2]]});
        n++;
        if (!ctl[7]) s = ctl[5] ? s - 4 : s + 4;
        d = ctl[4] ? d - 4 : d + 4;
      end
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input int cnt, input logic [31:0] ctl);
    logic [31:0] v;
    wr(1, s); wr(2, d); wr(3, cnt);
    wr(0, ctl | EN); wr(0, ctl | EN | SREQ);
    for (int k = 0; k < 3000; k++) begin
      rd(0, v);
      if (v[18] || v[20]) break;
    end
  endtask

  logic [31:0] v, g0;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = i * 32'h9E3779B9 + 32'h1357;
    repeat (3) @(negedge clk);
    rd(0, v); check(v == 0, "R1 control", v, 0);
    rd(6, v); check(v == 0, "R1 current count", v, 0);
    check(!mem_req && !irq, "R1 outputs", {mem_req, irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    wr(0, 32'hFFFEFFFE); rd(0, v); check(v == 32'h0000B3BC, "R2 control mask", v, 32'h0000B3BC);
    wr(0, 0); wr(4, 32'h55); rd(4, v); check(v == 0, "R2 read-only current", v, 0);
    wr(1, 32'h140); rd(1, v); check(v == 32'h140, "R2 source base", v, 32'h140);
    rd(7, v); check(v == 0, "R2 unused index", v, 0);

    g0 = grants; wr(0, SREQ); repeat (10) @(negedge clk);
    check(grants == g0, "R3 request without enable", grants, g0);
    rd(0, v); check(v == 0, "R3 control after ignored request", v, 0);

    push_exp(32'h100, 32'h400, 3, W32, 99);
    launch(32'h100, 32'h400, 3, W32);
    rd(0, v); check(v[18] && !v[20], "R8 terminal count single", v, TCB);
    check(exp_q.size() == 0, "R4 all single beats seen", exp_q.size(), 0);
    rd(4, v); check(v == 32'h10C, "R7 current source", v, 32'h10C);
    rd(5, v); check(v == 32'h40C, "R7 current destination", v, 32'h40C);
    rd(6, v); check(v == 0, "R7 current count", v, 0);

    wait_mode = 1;
    push_exp(32'h110, 32'h500, 2, W32 | BME | SIEN, 99);
    launch(32'h110, 32'h500, 2, W32 | BME | SIEN);
    check(exp_q.size() == 0, "R5 all burst beats seen", exp_q.size(), 0);
    check(irq == 1, "R12 irq with enable", irq, 1);
    wr(0, W32 | BME | SIEN | TCB); rd(0, v);
    check(!v[18], "R8 write-one clear", v, 0);
    check(irq == 0, "R12 irq after clear", irq, 0);

    wait_mode = 0;
    push_exp(32'h200, 32'h6F0, 2, W32 | BME | DDIR | SDIR, 99);
    launch(32'h200, 32'h6F0, 2, W32 | BME | DDIR | SDIR);
    rd(5, v); check(v == 32'h6D0, "R6 downward destination", v, 32'h6D0);
    rd(4, v); check(v == 32'h1E0, "R6 downward source", v, 32'h1E0);

    push_exp(32'h120, 32'h700, 1, W32 | BME | SFIX, 99);
    launch(32'h120, 32'h700, 1, W32 | BME | SFIX);
    rd(4, v); check(v == 32'h120, "R6 fixed source", v, 32'h120);
    check(exp_q.size() == 0, "R6 fixed source beats", exp_q.size(), 0);

    g0 = grants;
    launch(32'h108, 32'h800, 2, W32 | BME);
    rd(0, v); check(v[20] && !v[18], "R9 burst misalign error", v, ERRB);
    check(grants == g0, "R9 no bus traffic", grants, g0);
    wr(0, W32 | ERRB); rd(0, v); check(!v[20], "R10 error write-one clear", v, 0);
    launch(32'h100, 32'h800, 1, 32'h1000);
    rd(0, v); check(v[20], "R9 bad width error", v, ERRB);
    check(grants == g0, "R9 bad width no traffic", grants, g0);

    launch(32'h100, 32'h800, 0, W32);
    rd(0, v); check(v[18] && !v[20], "R8 zero count", v, TCB);
    check(grants == g0, "R8 zero count no traffic", grants, g0);

    err_en = 1; err_addr = 32'h308;
    push_exp(32'h300, 32'h900, 4, W32, 2);
    launch(32'h300, 32'h900, 4, W32);
    rd(0, v); check(v[20] && !v[18], "R10 fault flag", v, ERRB);
    check(exp_q.size() == 0 && !mem_req, "R10 stopped after fault", exp_q.size(), 0);
    rd(6, v); check(v == 2, "R10 count at fault", v, 2);
    err_en = 0;

    wait_mode = 3;
    push_exp(32'h140, 32'hA00, 8, W32, 99);
    wr(1, 32'h140); wr(2, 32'hA00); wr(3, 8); wr(0, W32 | EN); wr(0, W32 | EN | SREQ);
    repeat (12) @(negedge clk);
    wr(0, W32);
    repeat (12) @(negedge clk);
    check(!mem_req, "R11 abort stops requests", mem_req, 0);
    rd(0, v); check(!v[18] && !v[20], "R11 no flags after abort", v, 0);
    rd(6, v); check(v > 0 && v < 8, "R11 partial count", v, 4);
    check(exp_q.size() > 0, "R11 writes cut short", exp_q.size(), 1);
    exp_q.delete();
    wait_mode = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule